// File: doc/BRIEF.md
# Interrupt Raise/Acknowledge Controller

This block collects interrupt requests into a sticky pending-status word on a 32-bit register bus. Software sets pending bits by writing a value to a raise register, and every written one bit is OR-ed into the status word. Software clears pending bits by writing to an acknowledge register, and every written one bit is removed. Two internal engines, a factorial unit and a DMA unit, can also set fixed status bits through side inputs. Each of these inputs is gated by its own enable.

Delivery takes one of two forms, chosen by a mode input. In level mode the interrupt line stays high for as long as any status bit is set. In message mode the level line stays low. A single-cycle pulse marks each change of the status word from all-zero to non-zero. In both modes the handler has to acknowledge the bits, because a pending bit otherwise never drops.

A two-state delivery machine tracks whether the status word was non-zero. In state QUIET the status was zero on the previous cycle. When the status becomes non-zero, the transition QUIET->PENDING is taken and the message pulse is issued. In state PENDING the status was non-zero. When the status returns to zero, the transition PENDING->QUIET is taken. Both states stay where they are while the status keeps its zero or non-zero condition.

Top module: `irq_pend_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the status reads zero and irq_level and msg_pulse are low.
- R2: A write to offset 0x60 ORs the write data into the status; bits written as zero keep their value.
- R3: A write to offset 0x64 clears every status bit written as one; bits written as zero keep their value.
- R4: When an internal source sets a bit in the same cycle that an acknowledge clears that bit, the bit ends up set.
- R5: A factorial-done strobe with its enable high ORs 0x001 into the status; with the enable low it has no effect.
- R6: A DMA-done strobe with its enable high ORs 0x100 into the status; with the enable low it has no effect.
- R7: Reading offset 0x24 returns the status combinationally; reading any other offset returns zero.
- R8: Writes to offset 0x24 or to any offset other than 0x60 and 0x64 leave the status unchanged.
- R9: With msg_sel low (level mode), irq_level is high exactly while the status is non-zero, and msg_pulse stays low.
- R10: With msg_sel high (message mode), irq_level is low. msg_pulse is high for exactly one cycle, the first cycle in which the status reads non-zero after a cycle in which it read zero. Further bits set while the status is already non-zero raise no pulse.
- R11: With no write and no enabled source strobe, the status holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register byte offset for both read and write |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| fact_done | input | 1 | Factorial completion strobe |
| fact_irq_en | input | 1 | Enables the factorial status bit |
| dma_done | input | 1 | DMA completion strobe |
| dma_irq_en | input | 1 | Enables the DMA status bit |
| msg_sel | input | 1 | 0 selects level delivery, 1 selects message delivery |
| irq_level | output | 1 | Level interrupt line |
| msg_pulse | output | 1 | One-cycle message interrupt pulse |

## Verification
The bench builds the block with its default parameters. These are a 32-bit data word, an 8-bit offset, the offsets 0x24, 0x60 and 0x64, and the source values 0x001 and 0x100. With these values, raises, acknowledges and source strobes reach both the low bits and bit 8, so the case where a source beats a same-cycle acknowledge is seen on both source bits. The mode input is switched during the run. This exercises pulse generation on both QUIET->PENDING entries and the suppression of pulses while the status is already pending.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

    // Delivery state: whether the status word was non-zero last cycle
    typedef enum logic {
        ST_QUIET   = 1'b0,
        ST_PENDING = 1'b1
    } deliv_state_t;

endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] RAISE_OFF = 8'h60,
    parameter logic [ADDR_W-1:0] ACK_OFF   = 8'h64,
    parameter logic [DATA_W-1:0] FACT_VAL  = 32'h0000_0001,
    parameter logic [DATA_W-1:0] DMA_VAL   = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              fact_set,
    input  logic              dma_set,
    output logic [DATA_W-1:0] status_q
);

    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        if (bus_we && (bus_addr == RAISE_OFF)) begin
            set_vec = bus_wdata;
        end
        if (bus_we && (bus_addr == ACK_OFF)) begin
            clr_vec = bus_wdata;
        end
        if (fact_set) begin
            set_vec = set_vec | FACT_VAL;
        end
        if (dma_set) begin
            set_vec = set_vec | DMA_VAL;
        end
    end

    // One sticky cell per bit; setting takes priority over clearing
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                status_q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                status_q[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                status_q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_deliver_fsm.sv
module irq_deliver_fsm
    import irq_pend_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] status_q,
    input  logic              msg_sel,
    output logic              irq_level,
    output logic              msg_pulse
);

    deliv_state_t state_q;
    deliv_state_t state_d;
    logic         any_pend;

    assign any_pend = |status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        irq_level = 1'b0;
        msg_pulse = 1'b0;
        unique case (state_q)
            ST_QUIET: begin
                irq_level = !msg_sel && any_pend;
                msg_pulse = msg_sel && any_pend;
                if (any_pend) begin
                    state_d = ST_PENDING;
                end
            end
            ST_PENDING: begin
                irq_level = !msg_sel && any_pend;
                if (!any_pend) begin
                    state_d = ST_QUIET;
                end
            end
        endcase
    end

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] STAT_OFF  = 8'h24,
    parameter logic [ADDR_W-1:0] RAISE_OFF = 8'h60,
    parameter logic [ADDR_W-1:0] ACK_OFF   = 8'h64,
    parameter logic [DATA_W-1:0] FACT_VAL  = 32'h0000_0001,
    parameter logic [DATA_W-1:0] DMA_VAL   = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              fact_done,
    input  logic              fact_irq_en,
    input  logic              dma_done,
    input  logic              dma_irq_en,
    input  logic              msg_sel,
    output logic              irq_level,
    output logic              msg_pulse
);

    logic [DATA_W-1:0] status_q;
    logic              fact_set;
    logic              dma_set;

    assign fact_set = fact_done && fact_irq_en;
    assign dma_set  = dma_done && dma_irq_en;

    irq_status_reg #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .RAISE_OFF(RAISE_OFF),
        .ACK_OFF  (ACK_OFF),
        .FACT_VAL (FACT_VAL),
        .DMA_VAL  (DMA_VAL)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .fact_set (fact_set),
        .dma_set  (dma_set),
        .status_q (status_q)
    );

    irq_deliver_fsm #(
        .DATA_W(DATA_W)
    ) u_deliver (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_q (status_q),
        .msg_sel  (msg_sel),
        .irq_level(irq_level),
        .msg_pulse(msg_pulse)
    );

    // Only the status offset is readable
    assign bus_rdata = (bus_addr == STAT_OFF) ? status_q : '0;

endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] STAT_OFF  = 8'h24,
    parameter logic [ADDR_W-1:0] RAISE_OFF = 8'h60,
    parameter logic [ADDR_W-1:0] ACK_OFF   = 8'h64,
    parameter logic [DATA_W-1:0] FACT_VAL  = 32'h0000_0001,
    parameter logic [DATA_W-1:0] DMA_VAL   = 32'h0000_0100
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              fact_done,
    input logic              fact_irq_en,
    input logic              dma_done,
    input logic              dma_irq_en,
    input logic              msg_sel,
    input logic              irq_level,
    input logic              msg_pulse,
    input logic [DATA_W-1:0] status_q
);

    logic no_src;
    assign no_src = !(fact_done && fact_irq_en) && !(dma_done && dma_irq_en);

    a_r2_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == RAISE_OFF) |=>
            ((status_q & $past(bus_wdata)) == $past(bus_wdata)));

    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ACK_OFF && no_src) |=>
            ((status_q & $past(bus_wdata)) == '0));

    a_r5_fact_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (fact_done && fact_irq_en) |=> ((status_q & FACT_VAL) == FACT_VAL));

    a_r6_dma_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done && dma_irq_en) |=> ((status_q & DMA_VAL) == DMA_VAL));

    a_r8_stat_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == STAT_OFF && no_src) |=> $stable(status_q));

    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && no_src) |=> $stable(status_q));

    a_r9_level_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_sel |-> (irq_level == (status_q != '0)) && !msg_pulse);

    a_r10_no_level_in_msg: assert property (@(posedge clk) disable iff (!rst_n)
        msg_sel |-> !irq_level);

    a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        msg_pulse |=> !msg_pulse);

    a_r10_pulse_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        msg_pulse |-> (status_q != '0) && msg_sel);

endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .STAT_OFF (STAT_OFF),
    .RAISE_OFF(RAISE_OFF),
    .ACK_OFF  (ACK_OFF),
    .FACT_VAL (FACT_VAL),
    .DMA_VAL  (DMA_VAL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .fact_done  (fact_done),
    .fact_irq_en(fact_irq_en),
    .dma_done   (dma_done),
    .dma_irq_en (dma_irq_en),
    .msg_sel    (msg_sel),
    .irq_level  (irq_level),
    .msg_pulse  (msg_pulse),
    .status_q   (status_q)
);

// File: tb/irq_pend_ctrl_bench.sv
`timescale 1ns/1ps
module irq_pend_ctrl_bench;

    localparam logic [7:0] A_STAT  = 8'h24;
    localparam logic [7:0] A_RAISE = 8'h60;
    localparam logic [7:0] A_ACK   = 8'h64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = A_STAT;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fact_done = 1'b0;
    logic        fact_irq_en = 1'b0;
    logic        dma_done = 1'b0;
    logic        dma_irq_en = 1'b0;
    logic        msg_sel = 1'b0;
    logic        irq_level;
    logic        msg_pulse;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    logic [31:0] m_status = '0;
    bit          m_was_nz = 1'b0;

    always #4 clk = ~clk;

    irq_pend_ctrl u_irq_pend_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .fact_done  (fact_done),
        .fact_irq_en(fact_irq_en),
        .dma_done   (dma_done),
        .dma_irq_en (dma_irq_en),
        .msg_sel    (msg_sel),
        .irq_level  (irq_level),
        .msg_pulse  (msg_pulse)
    );

    // Behavioural model: advances on each rising edge
    always @(posedge clk) begin
        logic [31:0] nxt;
        if (!rst_n) begin
            m_status <= '0;
            m_was_nz <= 1'b0;
        end else begin
            nxt = m_status;
            if (bus_we && bus_addr == A_ACK)   nxt = nxt & ~bus_wdata;
            if (bus_we && bus_addr == A_RAISE) nxt = nxt | bus_wdata;
            if (fact_done && fact_irq_en)      nxt = nxt | 32'h001;
            if (dma_done && dma_irq_en)        nxt = nxt | 32'h100;
            m_was_nz <= (m_status != 0);
            m_status <= nxt;
        end
    end

    // Compare on every falling edge, before inputs move
    always @(negedge clk) begin
        logic [31:0] e_rd;
        bit e_lvl;
        bit e_pls;
        if (!done) begin
            e_rd  = (bus_addr == A_STAT) ? m_status : 32'h0;
            e_lvl = !msg_sel && (m_status != 0);
            e_pls = msg_sel && (m_status != 0) && !m_was_nz;
            n_cmp += 3;
            if (bus_rdata !== e_rd) begin
                n_bad++;
                $display("FAIL %s rdata actual=%h expected=%h", cur_req, bus_rdata, e_rd);
            end
            if (irq_level !== e_lvl) begin
                n_bad++;
                $display("FAIL %s irq_level actual=%b expected=%b", cur_req, irq_level, e_lvl);
            end
            if (msg_pulse !== e_pls) begin
                n_bad++;
                $display("FAIL %s msg_pulse actual=%b expected=%b", cur_req, msg_pulse, e_pls);
            end
        end
    end

    task automatic idle(input int n, input logic [7:0] raddr = A_STAT);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            bus_we = 1'b0; bus_addr = raddr; bus_wdata = '0;
            fact_done = 1'b0; dma_done = 1'b0;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        fact_done = 1'b0; dma_done = 1'b0;
        idle(1);
    endtask

    task automatic src(input bit f, input bit d);
        @(negedge clk); #1;
        bus_we = 1'b0; bus_addr = A_STAT;
        fact_done = f; dma_done = d;
        idle(1);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        idle(3);
        @(negedge clk); #1; rst_n = 1'b1;
        idle(2);

        cur_req = "R2";
        wr(A_RAISE, 32'h0000_0005);
        wr(A_RAISE, 32'h0000_0030);
        cur_req = "R9";
        idle(2);

        cur_req = "R3";
        wr(A_ACK, 32'h0000_0004);
        wr(A_ACK, 32'h0000_0031);
        idle(1);

        cur_req = "R7";
        wr(A_RAISE, 32'hA000_00A0);
        idle(1, 8'h20);
        idle(1, 8'h28);
        idle(1, A_RAISE);
        idle(1);

        cur_req = "R8";
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h61, 32'h0000_000F);

        cur_req = "R5";
        fact_irq_en = 1'b0;
        src(1'b1, 1'b0);
        fact_irq_en = 1'b1;
        src(1'b1, 1'b0);

        cur_req = "R6";
        dma_irq_en = 1'b0;
        src(1'b0, 1'b1);
        dma_irq_en = 1'b1;
        src(1'b0, 1'b1);

        cur_req = "R4";
        @(negedge clk); #1;
        bus_we = 1'b1; bus_addr = A_ACK; bus_wdata = 32'h0000_0101;
        fact_done = 1'b1; dma_done = 1'b1;
        idle(2);
        wr(A_ACK, 32'hFFFF_FFFF);
        idle(1);

        cur_req = "R10";
        msg_sel = 1'b1;
        idle(1);
        wr(A_RAISE, 32'h0000_0002);
        idle(1);
        wr(A_RAISE, 32'h0000_0004);
        src(1'b0, 1'b1);
        wr(A_ACK, 32'h0000_0106);
        idle(1);
        wr(A_RAISE, 32'h0000_0008);
        idle(2);
        msg_sel = 1'b0;
        idle(1);
        msg_sel = 1'b1;
        wr(A_ACK, 32'h0000_0008);
        src(1'b1, 1'b0);
        idle(1);

        cur_req = "R11";
        idle(5);
        wr(A_ACK, 32'hFFFF_FFFF);

        cur_req = "R1";
        @(negedge clk); #1; rst_n = 1'b0;
        idle(2);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule